// File: doc/BRIEF.md
# Grouped Priority Channel Arbiter

This block decides which of up to 32 DMA channels may drive the shared memory port next. Each channel belongs to one of four priority levels, and the level comes from bits 3:2 of the channel index. As a result, channels whose indices differ by 16 sit on the same level. The arbiter looks at the levels in ascending order, so level 0 is the most urgent. Within the first level that has an eligible requester, the lowest channel index wins. A channel is eligible when its request bit and its enable bit are both high.

The grant is held in a register and is offered on a valid/ready handshake. `gnt_valid` goes high with a one-hot vector and a channel number. The holder of the port raises `gnt_ready` in the cycle its burst finishes. While `gnt_valid` is high and `gnt_ready` is low, the grant must stay unchanged and is not re-evaluated. This is the back-pressure rule. In a cycle with no grant, or in a cycle where the handshake completes, the arbiter evaluates the request and enable inputs afresh. The outputs of that evaluation appear one clock later.

Next to the arbiter sits a summary register with one pending-interrupt bit per channel. A channel sets its bit with a set pulse, and software clears it with a write-one-to-clear pulse. A single interrupt line is the OR of all summary bits.

Top module: `grp_prio_arb`

## Requirements
- R1: After reset, `gnt_valid` is 0, `gnt_onehot` is all zero, `irq_pending` is all zero and `irq_line` is 0.
- R2: The priority level of channel c is (c mod 16) / 4, and level 0 is the highest. Channels 16–19 therefore compete on level 0 with channels 0–3. Any eligible channel on a lower-numbered level beats every channel on a higher-numbered level.
- R3: Among eligible channels on the same level, the one with the lowest index is granted.
- R4: Only channels with both `req[c]` and `ch_en[c]` high can receive a new grant. If the grant is free and no channel is eligible, `gnt_valid` is 0 in the next cycle.
- R5: A grant decided from the inputs of cycle n appears in cycle n+1. While `gnt_valid` is high, `gnt_onehot` has exactly bit `gnt_id` set. While `gnt_valid` is low, `gnt_onehot` is zero.
- R6: While `gnt_valid` is 1 and `gnt_ready` is 0, `gnt_valid`, `gnt_id` and `gnt_onehot` do not change, whatever the request and enable inputs do. In a cycle with `gnt_valid` and `gnt_ready` both high, the next grant is decided from that cycle's inputs.
- R7: A high `irq_set[c]` makes `irq_pending[c]` 1 in the next cycle. A high `irq_clr[c]` with a low `irq_set[c]` makes it 0. When both are high, set wins.
- R8: `irq_line` is 1 exactly when at least one bit of `irq_pending` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_CH | Per-channel request |
| ch_en | input | NUM_CH | Per-channel enable |
| gnt_ready | input | 1 | Burst of the granted channel finishes this cycle |
| gnt_valid | output | 1 | A grant is held |
| gnt_onehot | output | NUM_CH | One-hot grant vector |
| gnt_id | output | ID_W | Encoded granted channel |
| irq_set | input | NUM_CH | Per-channel interrupt event |
| irq_clr | input | NUM_CH | Write-one-to-clear for the summary bits |
| irq_pending | output | NUM_CH | Summary of pending interrupts |
| irq_line | output | 1 | OR of the summary bits |

## Verification
The bench builds the arbiter with NUM_CH = 24. With that value, channels 16–23 fold onto levels 0 and 1 alongside channels 0–7. Levels 2 and 3 are populated only by the lower half of the channel range. The wrap-around of the level rule and a partly populated upper range are therefore both exercised by one instance. A behavioural model keeps its own grant and summary state and searches levels and indices in plain loops. The bench compares against that model on every clock, through directed priority and hold cases and then a long random phase with random back-pressure.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

  // Width of an encoded channel number for a given channel count.
  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of priority levels actually populated by n channels.
  function automatic int unsigned level_count(input int unsigned n,
                                              input int unsigned per_lvl,
                                              input int unsigned period);
    if (n >= period) return period / per_lvl;
    return ((n - 1) / per_lvl) + 1;
  endfunction

endpackage

// File: rtl/gpa_level_mask.sv
module gpa_level_mask #(
  parameter int NUM_CH     = 32,
  parameter int CH_PER_LVL = 4,
  parameter int LVL_PERIOD = 16,
  parameter int NUM_LVL    = 4
) (
  input  logic [NUM_CH-1:0]               elig,
  output logic [NUM_LVL-1:0][NUM_CH-1:0]  lvl_req,
  output logic [NUM_LVL-1:0]              lvl_any
);

  // Each level keeps only the eligible channels that belong to it.
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (((c % LVL_PERIOD) / CH_PER_LVL) == l) begin : g_member
        assign lvl_req[l][c] = elig[c];
      end else begin : g_other
        assign lvl_req[l][c] = 1'b0;
      end
    end
    assign lvl_any[l] = |lvl_req[l];
  end

endmodule

// File: rtl/gpa_lowest_first.sv
module gpa_lowest_first #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          found
);

  // Isolate the lowest set bit.
  assign onehot = vec & (~vec + W'(1));
  assign found  = |vec;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/gpa_grant_reg.sv
module gpa_grant_reg #(
  parameter int NUM_CH = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_found,
  input  logic [NUM_CH-1:0] pick_onehot,
  input  logic [ID_W-1:0]   pick_id,
  input  logic              gnt_ready,
  output logic              gnt_valid,
  output logic [NUM_CH-1:0] gnt_onehot,
  output logic [ID_W-1:0]   gnt_id
);

  logic free;
  assign free = !gnt_valid || gnt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid  <= 1'b0;
      gnt_onehot <= '0;
      gnt_id     <= '0;
    end else if (free) begin
      gnt_valid  <= pick_found;
      gnt_onehot <= pick_found ? pick_onehot : '0;
      gnt_id     <= pick_found ? pick_id : '0;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot) && ((gnt_onehot != '0) == gnt_valid));

  // R5
  gnt_id_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_onehot[gnt_id]);

  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_id) && $stable(gnt_onehot)));

  // R4
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !pick_found) |=> !gnt_valid);

  // R5
  gnt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && pick_found) |=> gnt_valid);

endmodule

// File: rtl/gpa_irq_summary.sv
module gpa_irq_summary #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_set,
  input  logic [NUM_CH-1:0] irq_clr,
  output logic [NUM_CH-1:0] irq_pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pending <= '0;
    else        irq_pending <= (irq_pending & ~irq_clr) | irq_set;
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((irq_pending & $past(irq_set)) == $past(irq_set)));

  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_clr & ~irq_set) != '0) |=> ((irq_pending & $past(irq_clr & ~irq_set)) == '0));

endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb #(
  parameter int NUM_CH     = 32,
  parameter int CH_PER_LVL = 4,
  parameter int LVL_PERIOD = 16,
  parameter int ID_W       = gpa_pkg::id_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              gnt_ready,
  output logic              gnt_valid,
  output logic [NUM_CH-1:0] gnt_onehot,
  output logic [ID_W-1:0]   gnt_id,
  input  logic [NUM_CH-1:0] irq_set,
  input  logic [NUM_CH-1:0] irq_clr,
  output logic [NUM_CH-1:0] irq_pending,
  output logic              irq_line
);

  localparam int NUM_LVL = gpa_pkg::level_count(NUM_CH, CH_PER_LVL, LVL_PERIOD);

  logic [NUM_CH-1:0]              elig;
  logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_req;
  logic [NUM_LVL-1:0]             lvl_any;
  logic [NUM_CH-1:0]              sel_vec;
  logic [NUM_CH-1:0]              pick_onehot;
  logic [ID_W-1:0]                pick_id;
  logic                           pick_found;

  assign elig = req & ch_en;

  gpa_level_mask #(
    .NUM_CH(NUM_CH), .CH_PER_LVL(CH_PER_LVL),
    .LVL_PERIOD(LVL_PERIOD), .NUM_LVL(NUM_LVL)
  ) u_mask (
    .elig(elig), .lvl_req(lvl_req), .lvl_any(lvl_any)
  );

  // Most urgent populated level wins; lowest level number is most urgent.
  always_comb begin
    sel_vec = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (lvl_any[l]) sel_vec = lvl_req[l];
    end
  end

  gpa_lowest_first #(.W(NUM_CH), .IW(ID_W)) u_first (
    .vec(sel_vec), .onehot(pick_onehot), .idx(pick_id), .found(pick_found)
  );

  gpa_grant_reg #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_gnt (
    .clk(clk), .rst_n(rst_n),
    .pick_found(pick_found), .pick_onehot(pick_onehot), .pick_id(pick_id),
    .gnt_ready(gnt_ready),
    .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_id(gnt_id)
  );

  gpa_irq_summary #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .irq_set(irq_set), .irq_clr(irq_clr), .irq_pending(irq_pending)
  );

  assign irq_line = |irq_pending;

  // R4
  gnt_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_valid || gnt_ready) && (elig == '0)) |=> !gnt_valid);

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> irq_line);

endmodule

// File: tb/grp_prio_arb_tb.sv
module grp_prio_arb_tb;

  localparam int CLK_NS = 10;
  localparam int N      = 24;
  localparam int IW     = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, ch_en = '0, irq_set = '0, irq_clr = '0;
  logic          gnt_ready = 1'b0;
  logic          gnt_valid, irq_line;
  logic [N-1:0]  gnt_onehot, irq_pending;
  logic [IW-1:0] gnt_id;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  // Behavioural reference state
  bit           m_valid;
  int           m_id;
  logic [N-1:0] m_sum;

  always #(CLK_NS/2) clk = ~clk;

  grp_prio_arb #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ch_en(ch_en), .gnt_ready(gnt_ready),
    .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_id(gnt_id),
    .irq_set(irq_set), .irq_clr(irq_clr),
    .irq_pending(irq_pending), .irq_line(irq_line)
  );

  function automatic int ref_pick(input logic [N-1:0] v);
    for (int lvl = 0; lvl < 4; lvl++)
      for (int i = 0; i < N; i++)
        if (((i % 16) / 4) == lvl && v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0; m_id = 0; m_sum = '0;
    end else begin
      if (!m_valid || gnt_ready) begin
        int p;
        p = ref_pick(req & ch_en);
        m_valid = (p >= 0);
        m_id    = (p >= 0) ? p : 0;
      end
      m_sum = (m_sum & ~irq_clr) | irq_set;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      logic [N-1:0] exp_oh;
      exp_oh = m_valid ? (N'(1) << m_id) : '0;
      check(gnt_valid == m_valid, "R4 valid vs model", gnt_valid, m_valid);
      if (m_valid) check(int'(gnt_id) == m_id, "R2 id vs model", gnt_id, m_id);
      check(gnt_onehot == exp_oh, "R5 onehot vs model", gnt_onehot, exp_oh);
      check(irq_pending == m_sum, "R7 summary vs model", irq_pending, m_sum);
      check(irq_line == (m_sum != '0), "R8 line vs model", irq_line, m_sum != '0);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic expect_gnt(input int id, input string tag);
    check(gnt_valid == 1'b1, tag, gnt_valid, 1);
    check(int'(gnt_id) == id, tag, gnt_id, id);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check(gnt_valid == 0 && gnt_onehot == '0, "R1 grant after reset", gnt_valid, 0);
    check(irq_pending == '0 && irq_line == 0, "R1 summary after reset", irq_pending, 0);
    chk_on = 1'b1;

    ch_en = '1; gnt_ready = 1'b1;
    req = N'(1) << 4 | N'(1) << 17;
    cyc(); expect_gnt(17, "R2 wrapped ch17 beats level1 ch4");
    req = N'(1) << 1 | N'(1) << 5;
    cyc(); expect_gnt(1, "R2 level0 beats level1");
    req = N'(1) << 13 | N'(1) << 23;
    cyc(); expect_gnt(23, "R2 level1 ch23 beats level3 ch13");
    req = N'(1) << 3 | N'(1) << 16;
    cyc(); expect_gnt(3, "R3 lowest index in level");
    req = N'(1) << 19 | N'(1) << 2;
    cyc(); expect_gnt(2, "R3 lowest index in level");

    ch_en[0] = 1'b0;
    req = N'(1) << 0 | N'(1) << 9;
    cyc(); expect_gnt(9, "R4 disabled ch0 skipped");
    req = N'(1) << 0;
    cyc(); check(gnt_valid == 0, "R4 only disabled requester", gnt_valid, 0);
    ch_en = '1; req = '0;
    cyc(); check(gnt_valid == 0, "R4 no requester", gnt_valid, 0);

    req = N'(1) << 12;
    cyc(); expect_gnt(12, "R5 grant one cycle later");
    check(gnt_onehot == N'(1) << 12, "R5 onehot bit", gnt_onehot, N'(1) << 12);
    gnt_ready = 1'b0; req = N'(1) << 0;
    cyc(); expect_gnt(12, "R6 held without ready");
    ch_en = '0;
    cyc(); expect_gnt(12, "R6 held when enable drops");
    ch_en = '1; gnt_ready = 1'b1;
    cyc(); expect_gnt(0, "R6 re-evaluated at handshake");
    req = '0;
    cyc();

    irq_set = N'(1) << 5 | N'(1) << 20;
    cyc(); irq_set = '0;
    check(irq_pending == (N'(1) << 5 | N'(1) << 20), "R7 set bits", irq_pending, N'(1) << 5 | N'(1) << 20);
    check(irq_line == 1, "R8 line high", irq_line, 1);
    irq_clr = N'(1) << 5 | N'(1) << 20; irq_set = N'(1) << 20;
    cyc(); irq_clr = '0; irq_set = '0;
    check(irq_pending == N'(1) << 20, "R7 set wins over clear", irq_pending, N'(1) << 20);
    irq_clr = N'(1) << 20;
    cyc(); irq_clr = '0;
    check(irq_pending == '0, "R7 cleared", irq_pending, 0);
    check(irq_line == 0, "R8 line low", irq_line, 0);

    // Random phase, compared by the model on every clock.
    for (int k = 0; k < 3000; k++) begin
      req       = N'($urandom) & N'($urandom);
      ch_en     = N'($urandom) | N'($urandom);
      gnt_ready = ($urandom % 3) == 0;
      irq_set   = (($urandom % 4) == 0) ? N'(1) << ($urandom % N) : '0;
      irq_clr   = (($urandom % 3) == 0) ? N'($urandom) : '0;
      cyc();
    end
    chk_on = 1'b0;
    finish_run();
  end

endmodule